// File: doc/BRIEF.md
# Decade Up/Down Counter with Cascade Outputs

A synchronous modulo counter, decade by default, that steps through 0..9 on the rising clock edge while its active-low enable is low. A direction input selects counting up (low) or down (high). Wrap-around happens in both directions: 9 to 0 going up and 0 to 9 going down. An active-low, level-sensitive load input forces the count to the parallel data word immediately, whatever the clock is doing. Load wins over counting.

Two outputs let stages be chained into multi-digit counters. The terminal-count flag is high whenever the count sits at its end value for the current direction. The active-low ripple output goes low in the low phase of the clock when that flag is high and the stage is enabled. Feed the ripple output to the next stage's enable when all stages share one clock, or to its clock when all stages share one enable.

Top module: `bcd_updown_counter`

## Requirements
- R1: While rst_ni is low the count is 0, asynchronously to the clock.
- R2: On a rising clock edge with en_ni low and down_i low, a count below 9 increases by one.
- R3: On a rising clock edge with en_ni high, the count keeps its value.
- R4: While load_ni is low, cnt_o equals data_i without waiting for a clock edge, and it follows changes of data_i.
- R5: Counting up from 9 gives 0.
- R6: Counting down (down_i high) lowers a nonzero count by one, and gives 9 from 0.
- R7: maxmin_o is high exactly when (count is 9 and down_i is low) or (count is 0 and down_i is high). The level of en_ni does not affect it.
- R8: rco_no is low exactly when maxmin_o is high, en_ni is low and clk_i is low. Otherwise it is high.
- R9: A rising clock edge while load_ni is low does not count. After load_ni returns high, counting resumes from the loaded value.
- R10: From a loaded code 10..15, counting up gives 0 and counting down lowers the code by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset to 0, active low |
| en_ni | input | 1 | Count enable, active low |
| down_i | input | 1 | Direction: 0 up, 1 down |
| load_ni | input | 1 | Asynchronous parallel load, active low |
| data_i | input | 4 | Parallel load value |
| cnt_o | output | 4 | Current count |
| maxmin_o | output | 1 | Terminal-count flag for the current direction |
| rco_no | output | 1 | Ripple-clock cascade pulse, active low |

## Verification
The bench uses the default modulus of ten. With that value the four-bit data input can also carry the unused codes 10 to 15, so the escape from those codes is tested through a load. The decade bound puts both wrap points within a handful of edges, and the bench follows the documented sequence: load seven, count up through the wrap, inhibit, then count back down through the wrap. It also pulls load low in the middle of the low clock phase to show the asynchronous path, and it samples the ripple output in both clock phases.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/bcd_step.sv
`timescale 1ns/1ps
// Next-count logic for one enabled edge.
module bcd_step #(
  parameter int MODULUS = 10,
  parameter int CNT_W   = $clog2(MODULUS)
) (
  input  logic [CNT_W-1:0] cur_i,
  input  bcd_pkg::dir_e    dir_i,
  output logic [CNT_W-1:0] nxt_o
);
  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MODULUS - 1);

  always_comb begin
    if (dir_i == bcd_pkg::DIR_UP) begin
      // codes at or above the top value (incl. unused ones) escape to 0
      nxt_o = (cur_i >= TOP_VAL) ? '0 : cur_i + 1'b1;
    end else begin
      nxt_o = (cur_i == '0) ? TOP_VAL : cur_i - 1'b1;
    end
  end
endmodule

// File: rtl/bcd_term.sv
`timescale 1ns/1ps
// Terminal-count decode: end value for the selected direction.
module bcd_term #(
  parameter int MODULUS = 10,
  parameter int CNT_W   = $clog2(MODULUS)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  bcd_pkg::dir_e    dir_i,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MODULUS - 1);

  logic at_top, at_bot;
  assign at_top = (cnt_i == TOP_VAL);
  assign at_bot = (cnt_i == '0);

  always_comb begin
    unique case (dir_i)
      bcd_pkg::DIR_UP:   term_o = at_top;
      bcd_pkg::DIR_DOWN: term_o = at_bot;
      default:           term_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcd_ripple.sv
`timescale 1ns/1ps
// Cascade pulse: low during the low clock phase at terminal count when enabled.
module bcd_ripple (
  input  logic clk_i,
  input  logic en_ni,
  input  logic term_i,
  output logic rco_no
);
  assign rco_no = ~(term_i & ~en_ni & ~clk_i);
endmodule

// File: rtl/bcd_updown_counter.sv
`timescale 1ns/1ps
module bcd_updown_counter #(
  parameter int MODULUS = 10,
  parameter int CNT_W   = $clog2(MODULUS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             down_i,
  input  logic             load_ni,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             maxmin_o,
  output logic             rco_no
);
  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MODULUS - 1);

  bcd_pkg::dir_e    dir;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign dir = bcd_pkg::dir_e'(down_i);

  bcd_step #(.MODULUS(MODULUS), .CNT_W(CNT_W)) i_step (
    .cur_i (cnt_q),
    .dir_i (dir),
    .nxt_o (cnt_nxt)
  );

  // load is level sensitive: capture on its fall and on every edge it is held
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!load_ni) cnt_q <= data_i;
    else if (!en_ni)   cnt_q <= cnt_nxt;
  end

  // transparent path while load is held low
  assign cnt_o = load_ni ? cnt_q : data_i;

  bcd_term #(.MODULUS(MODULUS), .CNT_W(CNT_W)) i_term (
    .cnt_i  (cnt_o),
    .dir_i  (dir),
    .term_o (maxmin_o)
  );

  bcd_ripple i_ripple (
    .clk_i  (clk_i),
    .en_ni  (en_ni),
    .term_i (maxmin_o),
    .rco_no (rco_no)
  );

  // ---- assertions ----
  // set when load was low at any time since the previous rising edge
  logic ld_hit_q;
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)       ld_hit_q <= 1'b1;
    else if (!load_ni) ld_hit_q <= 1'b1;
    else               ld_hit_q <= 1'b0;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !ld_hit_q && $past(en_ni)) |-> (cnt_o == $past(cnt_o))); // R3

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !ld_hit_q && !$past(en_ni) && !$past(down_i) && $past(cnt_o) < TOP_VAL)
    |-> (cnt_o == $past(cnt_o) + 1'b1)); // R2

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !ld_hit_q && !$past(en_ni) && !$past(down_i) && $past(cnt_o) == TOP_VAL)
    |-> (cnt_o == '0)); // R5

  AST_DN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !ld_hit_q && !$past(en_ni) && $past(down_i) && $past(cnt_o) == '0)
    |-> (cnt_o == TOP_VAL)); // R6

  AST_FLAG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    maxmin_o |-> (cnt_o == '0 || cnt_o == TOP_VAL)); // R7

  AST_RIPPLE_HIGH_PHASE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rco_no); // R8
endmodule

// File: tb/test_bcd_updown_counter.sv
`timescale 1ns/1ps
module test_bcd_updown_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_n = 1'b1;
  logic       down = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] data = '0;
  logic [3:0] cnt;
  logic       maxmin, rco_n;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bcd_updown_counter i_bcd_updown_counter (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .down_i(down),
    .load_ni(load_n), .data_i(data), .cnt_o(cnt), .maxmin_o(maxmin), .rco_no(rco_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // rising edge, then settle inside the high phase
  task automatic tick();
    @(posedge clk); #1;
  endtask

  // pulse load inside the high phase
  task automatic do_load(input logic [3:0] v);
    data = v; load_n = 1'b0; #1; load_n = 1'b1; #1;
  endtask

  task automatic t_reset();
    chk("R1 reset count", cnt, 0);
    chk("R8 rco idle in reset", rco_n, 1);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R1 held after release", cnt, 0);
  endtask

  task automatic t_example();
    int up_seq[5] = '{8, 9, 0, 1, 2};
    int dn_seq[5] = '{1, 0, 9, 8, 7};
    do_load(4'd7);
    chk("R4 load seven", cnt, 7);
    en_n = 1'b0; down = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(i == 2 ? "R5 up wrap" : "R2 up step", cnt, up_seq[i]);
    end
    en_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R3 inhibit hold", cnt, 2);
    end
    en_n = 1'b0; down = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(i == 2 ? "R6 down wrap" : "R6 down step", cnt, dn_seq[i]);
    end
  endtask

  task automatic t_flags();
    en_n = 1'b1; down = 1'b0;
    do_load(4'd9);
    chk("R7 flag at 9 up, disabled", maxmin, 1);
    @(negedge clk); #1;
    chk("R8 no pulse when disabled", rco_n, 1);
    tick();
    en_n = 1'b0;
    chk("R8 no pulse in high phase", rco_n, 1);
    @(negedge clk); #1;
    chk("R8 pulse in low phase", rco_n, 0);
    chk("R7 flag at 9 up", maxmin, 1);
    tick();
    chk("R5 wrap to 0", cnt, 0);
    chk("R7 no flag at 0 up", maxmin, 0);
    en_n = 1'b1;
    down = 1'b1; #1;
    chk("R7 flag at 0 down", maxmin, 1);
    do_load(4'd9);
    chk("R7 no flag at 9 down", maxmin, 0);
    @(negedge clk); #1;
    chk("R8 no pulse without flag", rco_n, 1);
  endtask

  task automatic t_async_load();
    tick();
    en_n = 1'b1; down = 1'b0;
    do_load(4'd3);
    en_n = 1'b0;
    @(negedge clk); #2;
    data = 4'd5; load_n = 1'b0; #1;
    chk("R4 immediate load in low phase", cnt, 5);
    data = 4'd6; #1;
    chk("R4 follows data", cnt, 6);
    tick();
    chk("R9 no count while loading", cnt, 6);
    load_n = 1'b1; #1;
    chk("R9 value kept on release", cnt, 6);
    tick();
    chk("R9 resume from loaded", cnt, 7);
  endtask

  task automatic t_illegal();
    en_n = 1'b1; down = 1'b0;
    do_load(4'd12);
    en_n = 1'b0;
    tick();
    chk("R10 up from 12", cnt, 0);
    en_n = 1'b1; down = 1'b1;
    do_load(4'd13);
    en_n = 1'b0;
    tick();
    chk("R10 down from 13", cnt, 12);
  endtask

  task automatic t_reset_mid();
    en_n = 1'b1; down = 1'b0;
    do_load(4'd4);
    #1 rst_n = 1'b0; #1;
    chk("R1 async clear", cnt, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    #2;
    t_reset();
    t_example();
    t_flags();
    t_async_load();
    t_illegal();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule